// File: doc/BRIEF.md
# Fused Read-Modify-Write Memory Operation Unit

This unit carries out the fused read-modify-write instructions of an 8-bit processor. An earlier stage has already computed the effective address and read the memory byte. That stage hands the unit four things: the opcode, the byte read, the current accumulator, and the four arithmetic flags. The unit then works in two steps. First it modifies the byte with a shift, a rotate, an increment or a decrement. Then it folds the new byte into the accumulator with OR, AND, XOR, add, subtract or compare.

The unit drives two write beats in a fixed order. The first writes the byte back unchanged. The second writes the modified byte. After that it presents the new accumulator, the new flags and the total cycle count of the instruction. The cycle count depends on the addressing mode, which the unit decodes from the opcode. Addresses and the bus itself are handled elsewhere.

The sequencer has five states: IDLE, CALC, WR_ORIG, WR_MOD and DONE. Its transitions are:
- IDLE to CALC on an accepted request.
- CALC to WR_ORIG for a supported opcode.
- CALC to DONE for an unsupported opcode.
- WR_ORIG to WR_MOD, always.
- WR_MOD to DONE, always.
- DONE to IDLE when `out_ready` is high.

In CALC all results are registered from the captured request.

Top module: `rmw_fused_unit`

## Requirements
- R1: `in_ready` is high only in IDLE. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. Input values presented at any other time have no effect.
- R2: For a supported opcode, `wr_en` is high in the second cycle after acceptance with the unchanged byte on `wr_data`. It is high again in the third cycle with the modified byte. In the fourth cycle `out_valid` rises. `out_valid`, `acc_out`, `flags_out` and `cycles` then hold until a clock edge with `out_ready` high.
- R3: An opcode is supported when bits [1:0] are 11, bits [4:2] are not 010, and bits [7:5] are not 100 or 101. For any other opcode there is no write. `out_valid` rises in the second cycle, the accumulator and flags pass through unchanged, and `cycles` is 0.
- R4: Opcode bits [7:5] = 000: memory is shifted left with a zero entering bit 0. C takes the old bit 7. A becomes A OR the new byte. N and Z follow A.
- R5: Bits [7:5] = 001: memory is rotated left, with the incoming carry entering bit 0. C takes the old bit 7. A becomes A AND the new byte. N and Z follow A.
- R6: Bits [7:5] = 010: memory is shifted right with a zero entering bit 7. C takes the old bit 0. A becomes A XOR the new byte. N and Z follow A.
- R7: Bits [7:5] = 011: memory is rotated right, with the incoming carry entering bit 7. The bit rotated out then acts as carry-in to A + new byte. C is the adder carry-out and V is the signed overflow. N and Z follow A.
- R8: Bits [7:5] = 110: memory is decremented modulo 256. A is compared with the new byte and A is left unchanged. C is set when A >= new byte, Z when they are equal, and N takes bit 7 of A minus the new byte.
- R9: Bits [7:5] = 111: memory is incremented modulo 256. A becomes A minus the new byte minus (1 - C). C is set when no borrow occurs and V is the signed overflow. N and Z follow A.
- R10: `cycles` is set by opcode bits [4:0]:

  | Bits [4:0] | Addressing mode | Cycles |
  |---|---|---|
  | 00111 | zero page | 5 |
  | 10111 | zero page indexed | 6 |
  | 01111 | absolute | 6 |
  | 11011 | absolute indexed by Y | 7 |
  | 11111 | absolute indexed by X | 7 |
  | 00011 | indexed indirect | 8 |
  | 10011 | indirect indexed | 8 |

- R11: Flags are packed as {N, V, Z, C} in bits 3 down to 0. A flag that an operation does not list keeps its input value, so V is preserved for R4, R5, R6 and R8. There is no decimal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request (IDLE) |
| opcode | input | 8 | Instruction opcode |
| mem_rd | input | DW | Byte read from the effective address |
| acc_in | input | DW | Current accumulator |
| flags_in | input | 4 | Current {N,V,Z,C} |
| wr_en | output | 1 | Write beat active |
| wr_data | output | DW | Byte to write in this beat |
| out_valid | output | 1 | Results valid (DONE) |
| out_ready | input | 1 | Consumer takes the results |
| acc_out | output | DW | New accumulator |
| flags_out | output | 4 | New {N,V,Z,C} |
| cycles | output | CYC_W | Total instruction cycle count |

## Verification
Result hand-off and request intake can meet in one cycle. To provoke this, the bench raises a fresh `in_valid`, carrying different values, while DONE is still waiting on `out_ready`, and it keeps that request up across the cycle in which `out_ready` releases the results. The bench then judges two things. The held outputs must not move, and `in_ready` must stay low. The stray request must also not be captured: one cycle later the unit is expected back in IDLE, and the next real request must produce results that depend only on its own values. Every opcode is swept with mixed operands, and each family is also swept over every memory byte, with expected bytes, flags and counts worked out arithmetically.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

    localparam int OP_W = 8;

    typedef enum logic [2:0] {
        FAM_ASL_OR,
        FAM_ROL_AND,
        FAM_LSR_XOR,
        FAM_ROR_ADD,
        FAM_DEC_CMP,
        FAM_INC_SUB,
        FAM_NONE
    } fam_e;

    typedef enum logic [2:0] {
        AM_ZP,
        AM_ZPX,
        AM_ABS,
        AM_ABSX,
        AM_ABSY,
        AM_INDX,
        AM_INDY,
        AM_NONE
    } mode_e;

    typedef struct packed {
        logic n;
        logic v;
        logic z;
        logic c;
    } flags_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CALC,
        S_WR_ORIG,
        S_WR_MOD,
        S_DONE
    } state_e;

endpackage

// File: rtl/rmw_decode.sv
module rmw_decode
    import rmw_pkg::*;
#(
    parameter int CYC_W    = 4,
    parameter int CYC_ZP   = 5,
    parameter int CYC_ZPX  = 6,
    parameter int CYC_ABS  = 6,
    parameter int CYC_ABSI = 7,
    parameter int CYC_IND  = 8
) (
    input  logic [OP_W-1:0]  opcode_i,
    output fam_e             fam_o,
    output mode_e            mode_o,
    output logic             ok_o,
    output logic [CYC_W-1:0] cycles_o
);

    fam_e  fam_raw;
    mode_e mode_raw;

    always_comb begin
        unique case (opcode_i[7:5])
            3'b000:  fam_raw = FAM_ASL_OR;
            3'b001:  fam_raw = FAM_ROL_AND;
            3'b010:  fam_raw = FAM_LSR_XOR;
            3'b011:  fam_raw = FAM_ROR_ADD;
            3'b110:  fam_raw = FAM_DEC_CMP;
            3'b111:  fam_raw = FAM_INC_SUB;
            default: fam_raw = FAM_NONE;
        endcase
    end

    always_comb begin
        mode_raw = AM_NONE;
        if (opcode_i[1:0] == 2'b11) begin
            unique case (opcode_i[4:2])
                3'b000:  mode_raw = AM_INDX;
                3'b001:  mode_raw = AM_ZP;
                3'b011:  mode_raw = AM_ABS;
                3'b100:  mode_raw = AM_INDY;
                3'b101:  mode_raw = AM_ZPX;
                3'b110:  mode_raw = AM_ABSY;
                3'b111:  mode_raw = AM_ABSX;
                default: mode_raw = AM_NONE;
            endcase
        end
    end

    always_comb begin
        ok_o   = (fam_raw != FAM_NONE) && (mode_raw != AM_NONE);
        fam_o  = ok_o ? fam_raw : FAM_NONE;
        mode_o = ok_o ? mode_raw : AM_NONE;
        unique case (mode_o)
            AM_ZP:           cycles_o = CYC_W'(CYC_ZP);
            AM_ZPX:          cycles_o = CYC_W'(CYC_ZPX);
            AM_ABS:          cycles_o = CYC_W'(CYC_ABS);
            AM_ABSX, AM_ABSY: cycles_o = CYC_W'(CYC_ABSI);
            AM_INDX, AM_INDY: cycles_o = CYC_W'(CYC_IND);
            default:         cycles_o = '0;
        endcase
    end

endmodule

// File: rtl/rmw_modify.sv
module rmw_modify
    import rmw_pkg::*;
#(
    parameter int DW = 8
) (
    input  fam_e          fam_i,
    input  logic [DW-1:0] mem_i,
    input  logic          cin_i,
    output logic [DW-1:0] mod_o,
    output logic          cout_o
);

    localparam logic [DW-1:0] ONE = DW'(1);

    always_comb begin
        mod_o  = mem_i;
        cout_o = cin_i;
        unique case (fam_i)
            FAM_ASL_OR: begin
                mod_o  = {mem_i[DW-2:0], 1'b0};
                cout_o = mem_i[DW-1];
            end
            FAM_ROL_AND: begin
                mod_o  = {mem_i[DW-2:0], cin_i};
                cout_o = mem_i[DW-1];
            end
            FAM_LSR_XOR: begin
                mod_o  = {1'b0, mem_i[DW-1:1]};
                cout_o = mem_i[0];
            end
            FAM_ROR_ADD: begin
                mod_o  = {cin_i, mem_i[DW-1:1]};
                cout_o = mem_i[0];
            end
            FAM_DEC_CMP: mod_o = mem_i - ONE;
            FAM_INC_SUB: mod_o = mem_i + ONE;
            default: ;
        endcase
    end

endmodule

// File: rtl/rmw_combine.sv
module rmw_combine
    import rmw_pkg::*;
#(
    parameter int DW = 8
) (
    input  fam_e          fam_i,
    input  logic [DW-1:0] acc_i,
    input  logic [DW-1:0] mod_i,
    input  logic          shc_i,
    input  flags_t        flg_i,
    output logic [DW-1:0] acc_o,
    output flags_t        flg_o
);

    logic [DW-1:0] addend;
    logic          add_cin;
    logic [DW:0]   sum;
    logic [DW:0]   diff;
    logic          ovf;

    // One adder serves both add and subtract-with-borrow.
    always_comb begin
        addend  = (fam_i == FAM_INC_SUB) ? ~mod_i : mod_i;
        add_cin = (fam_i == FAM_INC_SUB) ? flg_i.c : shc_i;
        sum     = {1'b0, acc_i} + {1'b0, addend} + {{DW{1'b0}}, add_cin};
        diff    = {1'b0, acc_i} - {1'b0, mod_i};
        ovf     = (acc_i[DW-1] == addend[DW-1]) && (sum[DW-1] != acc_i[DW-1]);
    end

    always_comb begin
        acc_o = acc_i;
        flg_o = flg_i;
        unique case (fam_i)
            FAM_ASL_OR: begin
                acc_o   = acc_i | mod_i;
                flg_o.c = shc_i;
            end
            FAM_ROL_AND: begin
                acc_o   = acc_i & mod_i;
                flg_o.c = shc_i;
            end
            FAM_LSR_XOR: begin
                acc_o   = acc_i ^ mod_i;
                flg_o.c = shc_i;
            end
            FAM_ROR_ADD, FAM_INC_SUB: begin
                acc_o   = sum[DW-1:0];
                flg_o.c = sum[DW];
                flg_o.v = ovf;
            end
            default: ;
        endcase
        if (fam_i == FAM_DEC_CMP) begin
            flg_o.n = diff[DW-1];
            flg_o.z = (diff[DW-1:0] == '0);
            flg_o.c = ~diff[DW];
        end else if (fam_i != FAM_NONE) begin
            flg_o.n = acc_o[DW-1];
            flg_o.z = (acc_o == '0);
        end
    end

endmodule

// File: rtl/rmw_fused_unit.sv
module rmw_fused_unit
    import rmw_pkg::*;
#(
    parameter int DW    = 8,
    parameter int CYC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [7:0]       opcode,
    input  logic [DW-1:0]    mem_rd,
    input  logic [DW-1:0]    acc_in,
    input  logic [3:0]       flags_in,
    output logic             wr_en,
    output logic [DW-1:0]    wr_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [DW-1:0]    acc_out,
    output logic [3:0]       flags_out,
    output logic [CYC_W-1:0] cycles
);

    state_e state, nxt;

    logic [OP_W-1:0]  op_q;
    logic [DW-1:0]    mem_q;
    logic [DW-1:0]    acc_q;
    flags_t           flg_q;
    logic [DW-1:0]    mod_q;
    logic [DW-1:0]    acc_res_q;
    flags_t           flg_res_q;
    logic [CYC_W-1:0] cyc_q;

    fam_e             fam;
    mode_e            mode;
    logic             op_ok;
    logic [CYC_W-1:0] dec_cycles;
    logic [DW-1:0]    mod_w;
    logic             shc_w;
    logic [DW-1:0]    acc_w;
    flags_t           flg_w;
    logic             accept;

    rmw_decode #(.CYC_W(CYC_W)) u_decode (
        .opcode_i (op_q),
        .fam_o    (fam),
        .mode_o   (mode),
        .ok_o     (op_ok),
        .cycles_o (dec_cycles)
    );

    rmw_modify #(.DW(DW)) u_modify (
        .fam_i  (fam),
        .mem_i  (mem_q),
        .cin_i  (flg_q.c),
        .mod_o  (mod_w),
        .cout_o (shc_w)
    );

    rmw_combine #(.DW(DW)) u_combine (
        .fam_i (fam),
        .acc_i (acc_q),
        .mod_i (mod_w),
        .shc_i (shc_w),
        .flg_i (flg_q),
        .acc_o (acc_w),
        .flg_o (flg_w)
    );

    assign accept = in_valid && in_ready;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // Transitions
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:    if (accept) nxt = S_CALC;
            S_CALC:    nxt = op_ok ? S_WR_ORIG : S_DONE;
            S_WR_ORIG: nxt = S_WR_MOD;
            S_WR_MOD:  nxt = S_DONE;
            S_DONE:    if (out_ready) nxt = S_IDLE;
            default:   nxt = S_IDLE;
        endcase
    end

    // Request capture and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q      <= '0;
            mem_q     <= '0;
            acc_q     <= '0;
            flg_q     <= '0;
            mod_q     <= '0;
            acc_res_q <= '0;
            flg_res_q <= '0;
            cyc_q     <= '0;
        end else if (accept) begin
            op_q  <= opcode;
            mem_q <= mem_rd;
            acc_q <= acc_in;
            flg_q <= flags_t'(flags_in);
        end else if (state == S_CALC) begin
            mod_q     <= mod_w;
            acc_res_q <= acc_w;
            flg_res_q <= flg_w;
            cyc_q     <= dec_cycles;
        end
    end

    // Outputs
    always_comb begin
        in_ready  = (state == S_IDLE);
        wr_en     = (state == S_WR_ORIG) || (state == S_WR_MOD);
        wr_data   = (state == S_WR_MOD) ? mod_q : mem_q;
        out_valid = (state == S_DONE);
        acc_out   = acc_res_q;
        flags_out = flg_res_q;
        cycles    = cyc_q;
    end

    // R1
    accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !in_ready);

    // R2
    first_write_pairs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_en) |=> wr_en);

    // R2
    second_write_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && state == S_WR_MOD) |=> (!wr_en && out_valid));

    // R2
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(acc_out)
                                       && $stable(flags_out) && $stable(cycles)));

    // R3
    unsupported_no_cycles_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !op_ok) |-> (cycles == '0 && acc_out == acc_q));

    // R8
    compare_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && fam == FAM_DEC_CMP) |-> (acc_out == acc_q));

    // R10
    cycle_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && op_ok) |-> (cycles >= CYC_W'(5) && cycles <= CYC_W'(8)));

    // R11
    logic_keeps_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (fam == FAM_ASL_OR || fam == FAM_ROL_AND
                       || fam == FAM_LSR_XOR || fam == FAM_DEC_CMP))
        |-> (flags_out[2] == flg_q.v));

endmodule

// File: tb/tb_rmw_fused_unit.sv
module tb_rmw_fused_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] opcode = '0;
    logic [7:0] mem_rd = '0;
    logic [7:0] acc_in = '0;
    logic [3:0] flags_in = '0;
    logic       wr_en;
    logic [7:0] wr_data;
    logic       out_valid;
    logic       out_ready = 1'b0;
    logic [7:0] acc_out;
    logic [3:0] flags_out;
    logic [3:0] cycles;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    rmw_fused_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .opcode(opcode), .mem_rd(mem_rd), .acc_in(acc_in), .flags_in(flags_in),
        .wr_en(wr_en), .wr_data(wr_data), .out_valid(out_valid),
        .out_ready(out_ready), .acc_out(acc_out), .flags_out(flags_out),
        .cycles(cycles)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    function automatic string fam_tag(input logic [7:0] op);
        case (op[7:5])
            3'd0: return "R4";
            3'd1: return "R5";
            3'd2: return "R6";
            3'd3: return "R7";
            3'd6: return "R8";
            3'd7: return "R9";
            default: return "R3";
        endcase
    endfunction

    // Arithmetic reference built from the requirements
    task automatic model(input logic [7:0] op, input int m, input int a, input int f,
                         output bit ok, output int mo, output int ao,
                         output int fo, output int cyc);
        int hi = op[7:5];
        int n = (f >> 3) & 1;
        int v = (f >> 2) & 1;
        int z = (f >> 1) & 1;
        int c = f & 1;
        int s;
        int b;
        ok = 1;
        case (op[4:0])
            5'b00111: cyc = 5;
            5'b10111: cyc = 6;
            5'b01111: cyc = 6;
            5'b11011: cyc = 7;
            5'b11111: cyc = 7;
            5'b00011: cyc = 8;
            5'b10011: cyc = 8;
            default: begin cyc = 0; ok = 0; end
        endcase
        if (hi == 4 || hi == 5) ok = 0;
        mo = m;
        ao = a;
        if (!ok) begin
            cyc = 0;
            fo = f;
            return;
        end
        case (hi)
            0: begin mo = (m * 2) % 256; c = m / 128; ao = a | mo; end
            1: begin mo = (m * 2 + (f & 1)) % 256; c = m / 128; ao = a & mo; end
            2: begin mo = m / 2; c = m % 2; ao = a ^ mo; end
            3: begin
                mo = m / 2 + (f & 1) * 128;
                s = a + mo + (m % 2);
                ao = s % 256;
                c = (s > 255) ? 1 : 0;
                v = (((a ^ ao) & (mo ^ ao) & 128) != 0) ? 1 : 0;
            end
            6: begin
                mo = (m + 255) % 256;
                c = (a >= mo) ? 1 : 0;
                z = (a == mo) ? 1 : 0;
                n = (((a - mo + 256) % 256) >= 128) ? 1 : 0;
            end
            default: begin
                mo = (m + 1) % 256;
                b = 255 - mo;
                s = a + b + (f & 1);
                ao = s % 256;
                c = (s > 255) ? 1 : 0;
                v = (((a ^ ao) & (b ^ ao) & 128) != 0) ? 1 : 0;
            end
        endcase
        if (hi != 6) begin
            n = (ao >= 128) ? 1 : 0;
            z = (ao == 0) ? 1 : 0;
        end
        fo = n * 8 + v * 4 + z * 2 + c;
    endtask

    task automatic run_op(input logic [7:0] op, input int m, input int a, input int f);
        bit ok;
        int mo, ao, fo, cyc;
        int wcnt = 0;
        int w0 = -1, w1 = -1, wt0 = -1, wt1 = -1, vt = -1;
        string tag = fam_tag(op);
        model(op, m, a, f, ok, mo, ao, fo, cyc);
        @(negedge clk);
        opcode = op; mem_rd = m[7:0]; acc_in = a[7:0]; flags_in = f[3:0];
        in_valid = 1'b1;
        chk("R1", "ready in idle", int'(in_ready), 1);
        @(negedge clk);
        in_valid = 1'b0;
        opcode = ~op; mem_rd = ~mem_rd; acc_in = ~acc_in; flags_in = ~flags_in;
        chk("R1", "ready after accept", int'(in_ready), 0);
        for (int t = 1; t <= 8; t++) begin
            if (t > 1) @(negedge clk);
            if (wr_en) begin
                if (wcnt == 0) begin w0 = int'(wr_data); wt0 = t; end
                else begin w1 = int'(wr_data); wt1 = t; end
                wcnt++;
            end
            if (out_valid) begin vt = t; break; end
        end
        if (ok) begin
            chk("R2", "write count", wcnt, 2);
            chk("R2", "first write data", w0, m);
            chk("R2", "first write cycle", wt0, 2);
            chk(tag, "modified byte", w1, mo);
            chk("R2", "second write cycle", wt1, 3);
            chk("R2", "done cycle", vt, 4);
        end else begin
            chk("R3", "write count", wcnt, 0);
            chk("R3", "done cycle", vt, 2);
        end
        chk(tag, "accumulator", int'(acc_out), ao);
        chk(tag, "flags", int'(flags_out), fo);
        chk("R10", "cycles", int'(cycles), cyc);
        if (ok && (op[7:5] <= 3'd2 || op[7:5] == 3'd6))
            chk("R11", "V preserved", int'(flags_out[2]), (f >> 2) & 1);
        // stray request while results are held
        in_valid = 1'b1;
        opcode = 8'h07; mem_rd = 8'h5A; acc_in = 8'h3C; flags_in = 4'hF;
        @(negedge clk);
        chk("R1", "ready while held", int'(in_ready), 0);
        chk("R2", "valid held", int'(out_valid), 1);
        chk("R2", "acc held", int'(acc_out), ao);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        in_valid = 1'b0;
        chk("R1", "stray not taken", int'(in_ready), 1);
        chk("R2", "released", int'(out_valid), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "reset ready", int'(in_ready), 1);
        chk("R2", "reset valid", int'(out_valid), 0);
        chk("R2", "reset write", int'(wr_en), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "idle ready", int'(in_ready), 1);

        // every opcode with mixed operands
        for (int op = 0; op < 256; op++) begin
            for (int k = 0; k < 8; k++) begin
                run_op(op[7:0], (op * 29 + k * 71 + 13) % 256,
                       (op * 7 + k * 53) % 256, (k * 5 + op) % 16);
            end
        end

        // every memory byte for one opcode per family, both carries
        foreach (fam_ops[i]) begin
            for (int m = 0; m < 256; m++) begin
                run_op(fam_ops[i], m, (m * 3) % 256, 4'b0100);
                run_op(fam_ops[i], m, (m + 255) % 256, 4'b1011);
            end
        end

        // named corners
        run_op(8'hC7, 0, 8'hFF, 0);        // R8 decrement wraps, equal
        run_op(8'hE7, 8'hFF, 0, 1);        // R9 increment wraps
        run_op(8'h67, 8'h01, 8'h7F, 0);    // R7 rotated-out carry feeds add
        run_op(8'h27, 8'h80, 8'hFF, 1);    // R5 carry into bit 0
        run_op(8'h02, 8'h11, 8'h22, 4'h5); // R3 unsupported
        finish_run();
    end

    logic [7:0] fam_ops [6] = '{8'h07, 8'h27, 8'h47, 8'h67, 8'hC7, 8'hE7};

endmodule